// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a synthesizable behavioural model of a single-clock synchronous burst memory with a flow-through read path. The word is split into byte lanes of nine bits each: eight data bits and one parity bit. On each rising clock edge the block registers the address, the three chip enables, two address strobes, the advance input and the write controls. The read word is taken straight from the array at the registered address, so it appears in the same cycle in which that address was captured. An asynchronous output enable gates it.

The two strobes follow different rules. The processor strobe takes effect only when the primary enable is low, and it always reads. The controller strobe can read or write. If the primary enable is high, the controller strobe deselects the device instead. Between strobes, the advance input steps a two-bit burst counter or holds it, so the bus master can insert wait states. The counter follows either a wrapping linear order or an XOR (interleaved) order. A sleep input freezes the whole block. The shared data bus appears as separate input, output and output-valid ports.

Top module: `fts_burst_ram`

## Requirements
- R1: After reset the block is deselected and `q_oe_o` is low.
- R2: A controller strobe with `ce_n_i` low, `ce2_i` high and `ce2_n_i` low writes `d_i` to `addr_i` at that edge. A later controller-strobe read of that address presents the stored word on `q_o` with `q_oe_o` high in the cycle that directly follows the capturing edge.
- R3: An accepted processor strobe (`strb_p_n_i` low and `ce_n_i` low) loads `addr_i` and performs a read even when the write controls request a write. The array is not changed.
- R4: A processor strobe is ignored while `ce_n_i` is high. Such a cycle behaves as a continue or suspend cycle, and `addr_i` is not loaded.
- R5: A controller strobe with `ce_n_i` high deselects the device. `q_oe_o` then stays low, and advance cycles do not reselect it.
- R6: A strobe that is otherwise accepted deselects the device, with no write, when `ce2_i` is low or `ce2_n_i` is high.
- R7: Lane 0 is bits [8:0] (parity at bit 8) and lane 1 is bits [17:9] (parity at bit 17). If `gwr_n_i` is low, both lanes are written. If `gwr_n_i` is high and `bwe_n_i` is low, lane k is written when `lane_n_i[k]` is low. If `bwe_n_i` is high, or all lane enables are high, the cycle is a read.
- R8: After a processor-strobe read, a cycle with no strobe, `adv_n_i` high and a write request writes the address that was loaded.
- R9: With `burst_seq_i` low, each cycle with no strobe and `adv_n_i` low adds one to the two low address bits, wrapping modulo 4. With `burst_seq_i` high, the low bits are the start value XOR a 2-bit count, giving orders such as 1,0,3,2. After four steps the burst wraps back to the start address.
- R10: A cycle with no strobe and `adv_n_i` high keeps the current address (wait state).
- R11: `q_oe_o` is low after a write cycle until the next read cycle, and it is low whenever `oe_n_i` is high.
- R12: While `sleep_i` is high, `q_oe_o` is low, all other inputs are ignored, and the array and burst state are kept.
- R13: Continue cycles advance the burst while `ce_n_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | ADDR_W | External address |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce2_n_i | input | 1 | Secondary chip enable, active low |
| strb_p_n_i | input | 1 | Processor address strobe, active low |
| strb_c_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwr_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| lane_n_i | input | LANES | Per-lane write enables, active low |
| burst_seq_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Freeze and hold; output disabled |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| d_i | input | LANES*LANE_W | Write data |
| q_o | output | LANES*LANE_W | Flow-through read data |
| q_oe_o | output | 1 | Read data is being driven |

## Verification
The bench uses the default parameters: a 6-bit address (64 words), two 9-bit lanes and a 2-bit burst counter. With these values a four-word burst group can be filled and walked through in both orders, including the wrap back to the start. The parity bits and the lane split can each be checked with a single pattern. Every combination of strobe, enable and sleep needed for the deselect, ignore and write-after-read cases is driven explicitly.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/fts_ctl.sv
`timescale 1ns/1ps
module fts_ctl
  import fts_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n_i,
  input  logic             ce2_i,
  input  logic             ce2_n_i,
  input  logic             strb_p_n_i,
  input  logic             strb_c_n_i,
  input  logic             adv_n_i,
  input  logic             gwr_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] lane_n_i,
  input  logic             sleep_i,
  output logic             load_o,
  output logic             step_o,
  output logic [LANES-1:0] we_o,
  output logic             sel_o,
  output logic             rd_o
);
  logic             sel_q, sel_d;
  cyc_e             cyc_q, cyc_d;
  logic             sec_ok;
  logic [LANES-1:0] wr_mask;
  logic             p_acc;
  logic             upd_en;

  assign sec_ok = ce2_i & ~ce2_n_i;
  assign p_acc  = ~strb_p_n_i & ~ce_n_i;
  assign upd_en = ~sleep_i;

  always_comb begin
    if (!gwr_n_i)      wr_mask = '1;
    else if (!bwe_n_i) wr_mask = ~lane_n_i;
    else               wr_mask = '0;
  end

  always_comb begin
    load_o = 1'b0;
    step_o = 1'b0;
    we_o   = '0;
    sel_d  = sel_q;
    cyc_d  = cyc_q;
    if (!sleep_i) begin
      if (p_acc) begin
        load_o = 1'b1;
        sel_d  = sec_ok;
        cyc_d  = sec_ok ? CK_READ : CK_IDLE;
      end else if (!strb_c_n_i) begin
        if (ce_n_i) begin
          sel_d = 1'b0;
          cyc_d = CK_IDLE;
        end else begin
          load_o = 1'b1;
          sel_d  = sec_ok;
          if (sec_ok) begin
            we_o  = wr_mask;
            cyc_d = (|wr_mask) ? CK_WRITE : CK_READ;
          end else begin
            cyc_d = CK_IDLE;
          end
        end
      end else if (sel_q) begin
        step_o = ~adv_n_i;
        we_o   = wr_mask;
        cyc_d  = (|wr_mask) ? CK_WRITE : CK_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cyc_q <= CK_IDLE;
    end else if (upd_en) begin
      sel_q <= sel_d;
      cyc_q <= cyc_d;
    end
  end

  assign sel_o = sel_q;
  assign rd_o  = (cyc_q == CK_READ);
endmodule

// File: rtl/fts_burst_addr.sv
`timescale 1ns/1ps
module fts_burst_addr #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              seq_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  logic [ADDR_W-1:0]     base_q, base_d;
  logic [BURST_BITS-1:0] cnt_q, cnt_d;

  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [ADDR_W-1:0]     base,
    input logic [BURST_BITS-1:0] cnt,
    input logic                  seq
  );
    logic [BURST_BITS-1:0] low;
    low = seq ? (base[BURST_BITS-1:0] ^ cnt) : (base[BURST_BITS-1:0] + cnt);
    return {base[ADDR_W-1:BURST_BITS], low};
  endfunction

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      base_d = ext_addr_i;
      cnt_d  = '0;
    end else if (step_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i || step_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr_o = form_addr(base_q, cnt_q, seq_i);
  assign nxt_addr_o = form_addr(base_d, cnt_d, seq_i);
endmodule

// File: rtl/fts_lane_mem.sv
`timescale 1ns/1ps
module fts_lane_mem #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fts_burst_ram.sv
`timescale 1ns/1ps
module fts_burst_ram #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned LANES      = 2,
  parameter int unsigned LANE_W     = 9,
  parameter int unsigned BURST_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce_n_i,
  input  logic                    ce2_i,
  input  logic                    ce2_n_i,
  input  logic                    strb_p_n_i,
  input  logic                    strb_c_n_i,
  input  logic                    adv_n_i,
  input  logic                    gwr_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic                    burst_seq_i,
  input  logic                    sleep_i,
  input  logic                    oe_n_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_oe_o
);
  logic              load, step, sel, rd;
  logic [LANES-1:0]  we;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;

  fts_ctl #(.LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ce_n_i(ce_n_i), .ce2_i(ce2_i), .ce2_n_i(ce2_n_i),
    .strb_p_n_i(strb_p_n_i), .strb_c_n_i(strb_c_n_i), .adv_n_i(adv_n_i),
    .gwr_n_i(gwr_n_i), .bwe_n_i(bwe_n_i), .lane_n_i(lane_n_i),
    .sleep_i(sleep_i),
    .load_o(load), .step_o(step), .we_o(we), .sel_o(sel), .rd_o(rd)
  );

  fts_burst_addr #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .step_i(step), .seq_i(burst_seq_i),
    .ext_addr_i(addr_i),
    .cur_addr_o(cur_addr), .nxt_addr_o(nxt_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fts_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk(clk),
      .we_i(we[l]),
      .waddr_i(nxt_addr),
      .wdata_i(d_i[l*LANE_W +: LANE_W]),
      .raddr_i(cur_addr),
      .rdata_o(q_o[l*LANE_W +: LANE_W])
    );
  end

  assign q_oe_o = sel & rd & ~oe_n_i & ~sleep_i;
endmodule

// File: rtl/fts_burst_ram_chk.sv
`timescale 1ns/1ps
module fts_burst_ram_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n_i,
  input logic              ce2_i,
  input logic              ce2_n_i,
  input logic              strb_p_n_i,
  input logic              strb_c_n_i,
  input logic              adv_n_i,
  input logic              oe_n_i,
  input logic              sleep_i,
  input logic              q_oe_o,
  input logic [ADDR_W-1:0] cur_addr
);
  // R5
  ctl_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_c_n_i && strb_p_n_i && ce_n_i && !sleep_i) |=> !q_oe_o);

  // R6
  sec_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_c_n_i && !ce_n_i && (!ce2_i || ce2_n_i) && !sleep_i) |=> !q_oe_o);

  // R3
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_p_n_i && !ce_n_i && ce2_i && !ce2_n_i && !sleep_i)
      |=> (q_oe_o || oe_n_i || sleep_i));

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !q_oe_o);

  // R12
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !q_oe_o);

  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> $stable(cur_addr));

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_p_n_i && strb_c_n_i && adv_n_i) |=> $stable(cur_addr));
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ce_n_i(ce_n_i), .ce2_i(ce2_i), .ce2_n_i(ce2_n_i),
  .strb_p_n_i(strb_p_n_i), .strb_c_n_i(strb_c_n_i), .adv_n_i(adv_n_i),
  .oe_n_i(oe_n_i), .sleep_i(sleep_i), .q_oe_o(q_oe_o),
  .cur_addr(cur_addr)
);

// File: tb/fts_burst_ram_tb.sv
`timescale 1ns/1ps
module fts_burst_ram_tb;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic ce_n, ce2, ce2_n, strb_p_n, strb_c_n, adv_n, gwr_n, bwe_n;
  logic [1:0] lane_n;
  logic burst_seq, sleep, oe_n;
  logic [DW-1:0] d;
  logic [DW-1:0] q;
  logic q_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fts_burst_ram u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr),
    .ce_n_i(ce_n), .ce2_i(ce2), .ce2_n_i(ce2_n),
    .strb_p_n_i(strb_p_n), .strb_c_n_i(strb_c_n), .adv_n_i(adv_n),
    .gwr_n_i(gwr_n), .bwe_n_i(bwe_n), .lane_n_i(lane_n),
    .burst_seq_i(burst_seq), .sleep_i(sleep), .oe_n_i(oe_n),
    .d_i(d), .q_o(q), .q_oe_o(q_oe)
  );

  function automatic logic [DW-1:0] val(input int a);
    return DW'(a * 18'h0137 + 18'h10055);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ce_n = 0; ce2 = 1; ce2_n = 0;
    strb_p_n = 1; strb_c_n = 1; adv_n = 1;
    gwr_n = 1; bwe_n = 1; lane_n = 2'b11;
    sleep = 0; oe_n = 0;
  endtask

  task automatic wr_c(input int a, input logic [DW-1:0] v);
    idle(); addr = AW'(a); strb_c_n = 0; gwr_n = 0; d = v;
    tick(); idle();
  endtask

  task automatic rd_c(input int a);
    idle(); addr = AW'(a); strb_c_n = 0;
    tick(); idle();
  endtask

  task automatic t_reset();
    chk("R1 reset oe", DW'(q_oe), 18'd0);
  endtask

  task automatic t_basic();
    wr_c(5, val(5));
    chk("R11 oe after write", DW'(q_oe), 18'd0);
    rd_c(5);
    chk("R2 read oe", DW'(q_oe), 18'd1);
    chk("R2 read data", q, val(5));
    oe_n = 1; #1;
    chk("R11 oe_n high", DW'(q_oe), 18'd0);
    oe_n = 0; #1;
    chk("R11 oe_n low again", DW'(q_oe), 18'd1);
  endtask

  task automatic t_proc_read();
    idle(); addr = 6'd5; strb_p_n = 0; gwr_n = 0; d = 18'h3C3C3;
    tick(); idle();
    chk("R3 proc read oe", DW'(q_oe), 18'd1);
    chk("R3 proc read data", q, val(5));
    rd_c(5);
    chk("R3 array untouched", q, val(5));
  endtask

  task automatic t_write_after_p();
    wr_c(9, val(9));
    idle(); addr = 6'd9; strb_p_n = 0;
    tick(); idle();
    chk("R8 loaded read", q, val(9));
    gwr_n = 0; d = 18'h2AAAA; adv_n = 1;
    tick(); idle();
    chk("R11 hi-z after write", DW'(q_oe), 18'd0);
    adv_n = 1; tick();
    chk("R11 read cycle restores oe", DW'(q_oe), 18'd1);
    rd_c(9);
    chk("R8 written at loaded addr", q, 18'h2AAAA);
  endtask

  task automatic t_lanes();
    wr_c(30, 18'h3FFFF);
    idle(); addr = 6'd30; strb_c_n = 0; bwe_n = 0; lane_n = 2'b10; d = 18'h0;
    tick();
    rd_c(30);
    chk("R7 lane0 only", q, 18'h3FE00);
    idle(); addr = 6'd30; strb_c_n = 0; bwe_n = 0; lane_n = 2'b01; d = 18'h0;
    tick();
    rd_c(30);
    chk("R7 lane1 only", q, 18'h00000);
    idle(); addr = 6'd30; strb_c_n = 0; bwe_n = 1; lane_n = 2'b00; d = 18'h3FFFF;
    tick();
    chk("R7 bwe high reads oe", DW'(q_oe), 18'd1);
    chk("R7 bwe high reads data", q, 18'h00000);
    idle(); addr = 6'd30; strb_c_n = 0; bwe_n = 0; lane_n = 2'b11; d = 18'h3FFFF;
    tick();
    chk("R7 no lane reads", q, 18'h00000);
    idle(); addr = 6'd30; strb_c_n = 0; gwr_n = 0; bwe_n = 1; lane_n = 2'b11; d = 18'h21234;
    tick();
    rd_c(30);
    chk("R7 global write", q, 18'h21234);
  endtask

  task automatic t_bursts();
    for (int a = 16; a < 20; a++) wr_c(a, val(a));
    burst_seq = 0;
    rd_c(18);
    chk("R9 linear first", q, val(18));
    adv_n = 0; tick(); chk("R9 linear 2nd", q, val(19));
    tick(); chk("R9 linear 3rd", q, val(16));
    tick(); chk("R9 linear 4th", q, val(17));
    tick(); chk("R9 linear wrap", q, val(18));
    adv_n = 1; tick(); chk("R10 wait hold", q, val(18));
    ce_n = 1; adv_n = 0; tick();
    chk("R13 continue ce high", q, val(19));
    strb_p_n = 0; ce_n = 1; addr = 6'd40; adv_n = 0; tick();
    chk("R4 proc ignored data", q, val(16));
    chk("R4 proc ignored oe", DW'(q_oe), 18'd1);
    idle();
    burst_seq = 1;
    rd_c(17);
    chk("R9 inter first", q, val(17));
    adv_n = 0; tick(); chk("R9 inter 2nd", q, val(16));
    tick(); chk("R9 inter 3rd", q, val(19));
    tick(); chk("R9 inter 4th", q, val(18));
    tick(); chk("R9 inter wrap", q, val(17));
    idle(); burst_seq = 0;
  endtask

  task automatic t_deselect();
    rd_c(5);
    idle(); ce_n = 1; strb_c_n = 0; tick(); idle();
    chk("R5 ctl deselect", DW'(q_oe), 18'd0);
    adv_n = 0; tick();
    chk("R5 advance stays off", DW'(q_oe), 18'd0);
    idle(); addr = 6'd5; strb_c_n = 0; ce2 = 0; gwr_n = 0; d = 18'h11111;
    tick(); idle();
    chk("R6 ce2 low deselect", DW'(q_oe), 18'd0);
    rd_c(5);
    chk("R6 no write", q, val(5));
    idle(); addr = 6'd5; strb_p_n = 0; ce2_n = 1;
    tick(); idle();
    chk("R6 ce2_n high deselect", DW'(q_oe), 18'd0);
  endtask

  task automatic t_sleep();
    wr_c(12, val(12));
    rd_c(12);
    sleep = 1; #1;
    chk("R12 sleep oe", DW'(q_oe), 18'd0);
    addr = 6'd12; strb_c_n = 0; gwr_n = 0; d = 18'h15555;
    tick();
    idle(); sleep = 1; ce_n = 1; strb_c_n = 0;
    tick();
    idle(); sleep = 1; adv_n = 0;
    tick();
    sleep = 0; adv_n = 1; #1;
    chk("R12 wake oe", DW'(q_oe), 18'd1);
    chk("R12 wake data", q, val(12));
    rd_c(12);
    chk("R12 array kept", q, val(12));
  endtask

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; d = '0; burst_seq = 0;
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_basic();
    t_proc_read();
    t_write_after_p();
    t_lanes();
    t_bursts();
    t_deselect();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule